// File: doc/BRIEF.md
# Rotate-and-Mask Bitfield Unit

This unit takes a source word, rotates it left by a requested amount and then applies a mask to it. In extract mode the output holds only the rotated bits that the mask selects. In insert mode the selected rotated bits are written into a copy of a destination word, and every destination bit where the mask is clear keeps its value. A single operation therefore moves a field to a new position and then either isolates it or merges it into existing data.

One select input chooses between a full-width operation and a half-width operation. With the default parameters these are 64 bits and 32 bits. The unit itself is combinational, and a single register stage captures the result together with its zero and sign flags. A valid strobe comes out one clock after the input strobe. Carry and overflow have no meaning for this operation, and the unit drives both low.

Top module: `rmu_bitfield_unit`

## Requirements
- R1: With `mode_i`=0 (extract) and `wide_i`=1, `result_o` equals `src_i` rotated left by `rot_i`, ANDed with `mask_i`.
- R2: With `mode_i`=1 (insert) and `wide_i`=1, each result bit is the rotated source bit where `mask_i` is 1 and the `dst_i` bit where `mask_i` is 0.
- R3: With `wide_i`=0, only the low half of `src_i`, `dst_i` and `mask_i` is used, the rotation wraps within the low half, and the upper half of `result_o` is zero. This holds in both modes.
- R4: The rotate amount is reduced modulo the selected width. Full-width mode uses all of `rot_i`, and half-width mode uses only its low log2(half width) bits.
- R5: `zero_o` is 1 exactly when the registered `result_o` is 0.
- R6: `sign_o` equals the most significant bit of the result at the selected width. That is bit WIDE_W-1 when `wide_i`=1 and bit WIDE_W/2-1 when `wide_i`=0.
- R7: `carry_o` and `ovf_o` are always 0.
- R8: `valid_o` is 1 in the cycle after a cycle with `valid_i`=1 and 0 otherwise. Result and flags update in that same cycle.
- R9: While `rst_ni` is low, `valid_o`, `result_o`, `zero_o` and `sign_o` are all 0.
- R10: A cycle with `valid_i`=0 leaves `result_o`, `zero_o` and `sign_o` unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 1 | 0 = extract, 1 = insert |
| wide_i | input | 1 | 1 = full width, 0 = half width |
| src_i | input | WIDE_W | Source operand to rotate |
| dst_i | input | WIDE_W | Destination word for insert mode |
| mask_i | input | WIDE_W | Field mask |
| rot_i | input | log2(WIDE_W) | Left-rotate amount |
| valid_o | output | 1 | Result strobe, one clock after valid_i |
| result_o | output | WIDE_W | Registered result |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Top bit of result at selected width |
| carry_o | output | 1 | Constant 0 |
| ovf_o | output | 1 | Constant 0 |

## Verification
The bench builds the unit with WIDE_W=16, which makes the half width 8 bits and rot_i 4 bits wide. At this size every rotate amount can be swept in both widths and both modes. In half-width mode, amounts 8 to 15 exercise the wrap-around reduction. The data set includes fixed masks of all zeros and all ones, a single-bit source and pseudo-random words. The random words carry garbage in their upper halves, so the half-width isolation is tested, and the fixed masks drive both flags to each of their values.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  typedef enum logic {
    RMU_EXTRACT = 1'b0,
    RMU_INSERT  = 1'b1
  } rmu_mode_e;

  typedef struct packed {
    logic zero;
    logic sign;
  } rmu_flags_t;
endpackage

// File: rtl/rmu_rotl.sv
module rmu_rotl #(
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [AW:0] back_amt;

  always_comb begin
    back_amt = (AW+1)'(W) - {1'b0, amt_i};
    // shift by W yields 0, covering amt_i == 0
    data_o   = (data_i << amt_i) | (data_i >> back_amt);
  end
endmodule

// File: rtl/rmu_merge.sv
module rmu_merge
  import rmu_pkg::*;
#(
  parameter int unsigned WIDE_W   = 64,
  localparam int unsigned NARROW_W = WIDE_W / 2
) (
  input  logic [WIDE_W-1:0]   rot_wide_i,
  input  logic [NARROW_W-1:0] rot_narrow_i,
  input  logic [WIDE_W-1:0]   dst_i,
  input  logic [WIDE_W-1:0]   mask_i,
  input  logic                wide_i,
  input  rmu_mode_e           mode_i,
  output logic [WIDE_W-1:0]   res_o
);
  localparam logic [WIDE_W-1:0] LOW_KEEP = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] keep, rot_sel, m_eff, d_eff;

  always_comb begin
    keep    = wide_i ? '1 : LOW_KEEP;
    rot_sel = wide_i ? rot_wide_i : {{NARROW_W{1'b0}}, rot_narrow_i};
    m_eff   = mask_i & keep;
    d_eff   = dst_i & keep;
    res_o   = rot_sel & m_eff;
    if (mode_i == RMU_INSERT) res_o = res_o | (d_eff & ~m_eff);
  end
endmodule

// File: rtl/rmu_flags.sv
module rmu_flags
  import rmu_pkg::*;
#(
  parameter int unsigned WIDE_W   = 64,
  localparam int unsigned NARROW_W = WIDE_W / 2
) (
  input  logic [WIDE_W-1:0] res_i,
  input  logic              wide_i,
  output rmu_flags_t        flags_o
);
  always_comb begin
    flags_o.zero = (res_i == '0);
    flags_o.sign = wide_i ? res_i[WIDE_W-1] : res_i[NARROW_W-1];
  end
endmodule

// File: rtl/rmu_bitfield_unit.sv
module rmu_bitfield_unit
  import rmu_pkg::*;
#(
  parameter int unsigned WIDE_W   = 64,
  localparam int unsigned ROT_W    = $clog2(WIDE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] src_i,
  input  logic [WIDE_W-1:0] dst_i,
  input  logic [WIDE_W-1:0] mask_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic              valid_o,
  output logic [WIDE_W-1:0] result_o,
  output logic              zero_o,
  output logic              sign_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned NARROW_W = WIDE_W / 2;
  localparam int unsigned NROT_W   = $clog2(NARROW_W);

  logic [WIDE_W-1:0]   rot_wide, res_d;
  logic [NARROW_W-1:0] rot_narrow;
  rmu_flags_t          flags_d;
  logic                valid_q, zero_q, sign_q;
  logic [WIDE_W-1:0]   result_q;

  rmu_rotl #(.W(WIDE_W)) u_rot_wide (
    .data_i (src_i),
    .amt_i  (rot_i),
    .data_o (rot_wide)
  );

  // half width: low bits of amount give modulo reduction
  rmu_rotl #(.W(NARROW_W)) u_rot_narrow (
    .data_i (src_i[NARROW_W-1:0]),
    .amt_i  (rot_i[NROT_W-1:0]),
    .data_o (rot_narrow)
  );

  rmu_merge #(.WIDE_W(WIDE_W)) u_merge (
    .rot_wide_i   (rot_wide),
    .rot_narrow_i (rot_narrow),
    .dst_i        (dst_i),
    .mask_i       (mask_i),
    .wide_i       (wide_i),
    .mode_i       (rmu_mode_e'(mode_i)),
    .res_o        (res_d)
  );

  rmu_flags #(.WIDE_W(WIDE_W)) u_flags (
    .res_i   (res_d),
    .wide_i  (wide_i),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      zero_q   <= 1'b0;
      sign_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        result_q <= res_d;
        zero_q   <= flags_d.zero;
        sign_q   <= flags_d.sign;
      end
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
  assign zero_o   = zero_q;
  assign sign_o   = sign_q;
  assign carry_o  = 1'b0;
  assign ovf_o    = 1'b0;

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R8
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R1
  extract_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && !mode_i) |=> ((result_o & ~$past(mask_i)) == '0));
  // R2
  insert_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wide_i && mode_i) |=> (((result_o ^ $past(dst_i)) & ~$past(mask_i)) == '0));
  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wide_i) |=> (result_o[WIDE_W-1:NARROW_W] == '0));
  // R5
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (result_o == '0)));
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(zero_o) && $stable(sign_o));
endmodule

// File: tb/rmu_bitfield_unit_tb.sv
module rmu_bitfield_unit_tb_top;
  localparam int unsigned W      = 16;
  localparam int unsigned N      = W / 2;
  localparam int unsigned RW     = $clog2(W);
  localparam time         CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0, mode_i = 1'b0, wide_i = 1'b0;
  logic [W-1:0]  src_i = '0, dst_i = '0, mask_i = '0;
  logic [RW-1:0] rot_i = '0;
  logic          valid_o, zero_o, sign_o, carry_o, ovf_o;
  logic [W-1:0]  result_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PER/2) clk = ~clk;

  rmu_bitfield_unit #(.WIDE_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .wide_i(wide_i), .src_i(src_i), .dst_i(dst_i), .mask_i(mask_i),
    .rot_i(rot_i), .valid_o(valid_o), .result_o(result_o), .zero_o(zero_o),
    .sign_o(sign_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  function automatic logic [W-1:0] next_rand();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr[31:32-W];
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] s, d, m,
                                         input int a, input logic wide, ins);
    int w = wide ? W : N;
    int sh = a % w;
    logic [W-1:0] r = '0;
    for (int i = 0; i < w; i++) begin
      logic rb = s[(i + w - sh) % w];
      r[i] = m[i] ? rb : (ins ? d[i] : 1'b0);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] s, d, m, input int a,
                       input logic wide, ins);
    logic [W-1:0] e;
    string tag;
    @(negedge clk);
    valid_i = 1'b1; src_i = s; dst_i = d; mask_i = m;
    rot_i = RW'(a); wide_i = wide; mode_i = ins;
    e = model(s, d, m, a, wide, ins);
    @(negedge clk);
    if (!wide) tag = ins ? "R3/R4 narrow insert" : "R3/R4 narrow extract";
    else       tag = ins ? "R2 insert" : "R1 extract";
    check(tag, result_o, e);
    check("R8 valid_o", W'(valid_o), W'(1));
    check("R5 zero_o", W'(zero_o), W'(e == '0));
    check("R6 sign_o", W'(sign_o), W'(wide ? e[W-1] : e[N-1]));
    check("R7 carry/ovf", W'({carry_o, ovf_o}), '0);
  endtask

  initial begin : watchdog
    #(CLK_PER * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] s, d, m, held;
    logic hz, hs;
    #(CLK_PER * 2.3);
    // R9
    check("R9 reset valid", W'(valid_o), '0);
    check("R9 reset result", result_o, '0);
    check("R9 reset flags", W'({zero_o, sign_o}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int md = 0; md < 2; md++) begin
          for (int a = 0; a < W; a++) begin
            s = next_rand(); d = next_rand(); m = next_rand();
            case (p)
              1: m = '0;
              2: m = '1;
              3: s = '1;
              4: s = W'(1) << (a % W);
              5: begin s = '0; d = '0; end
              default: ;
            endcase
            apply(s, d, m, a, wd[0], md[0]);
          end
        end
      end
      // R10: idle cycle with disturbed inputs
      held = result_o; hz = zero_o; hs = sign_o;
      @(negedge clk);
      valid_i = 1'b0; src_i = ~src_i; dst_i = ~dst_i; mask_i = '1;
      rot_i = rot_i + 1'b1;
      @(negedge clk);
      check("R8 valid_o idle", W'(valid_o), '0);
      check("R10 hold result", result_o, held);
      check("R10 hold flags", W'({zero_o, sign_o}), W'({hz, hs}));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule